// File: doc/BRIEF.md
# UART Host Register Interface with Interrupt Logic

This block is the processor-facing register front end of a small single-channel UART. A 3-bit address, separate active-low read and write strobes and an active-low chip select give an 8-bit processor access to the channel. The same address can name different registers depending on the direction of the access. Two mode registers share address 0. A pointer chooses between them: it starts at the first mode register and moves to the second after the first access.

The block also keeps the interrupt mask and the interrupt status. The transmitter, receiver, counter/timer and a general input pin supply level conditions and one-cycle event pulses. Latched events and live levels together form an 8-bit status byte. The processor reads this byte unmasked, while the registered active-low interrupt line responds only to the bits enabled in the mask. The only commands decoded from the command byte are the pointer reset and the interrupt clears. The serial datapath, the baud generation and the counter are outside this block.

Top module: `uart_regbank`

## Requirements
- R1: A write starts when `cs_n` and `wr_n` are both low and were not both low on the previous clock. Each write is applied once, on that edge, no matter how long the strobe is held. The register written depends on the address: 1 clock select, 3 transmit holding (with `tx_load` high for exactly one clock), 4 auxiliary control, 5 interrupt mask, 6 counter preset upper byte, 7 counter preset lower byte.
- R2: `rd_data` is driven combinationally while `cs_n` and `rd_n` are both low, and is 0 otherwise. The source depends on the address: 1 `stat_in`, 2 `brg_probe`, 3 `rx_hold`, 4 `clk_probe`, 5 interrupt status, 6 `cnt_hi`, 7 `cnt_lo`.
- R3: Address 0 reads and writes `mode1` while the pointer is at the first mode register, and `mode2` otherwise. The start of any read or write at address 0 moves the pointer to the second mode register, and it stays there.
- R4: A write at address 2 whose bits [7:4] equal 0001 returns the pointer to the first mode register.
- R5: The interrupt status bits follow live levels: bit 0 follows `lvl_txrdy`, bit 1 follows `lvl_txemt`, bit 2 follows `lvl_rxrdy` and bit 6 follows `lvl_pin`. Bit 7 always reads 0.
- R6: Status bit 3 (break change) is set by `pls_brk`, bit 4 (counter ready) by `pls_cnt` and bit 5 (pin change) by `pls_pin`. Once set, each of these bits stays set until it is cleared.
- R7: A write at address 2 with bits [7:4] = 0101 clears bit 3, and one with bits [7:4] = 1001 clears bit 4. The start of a read at address 5 clears bit 5. When a set pulse and a clear arrive in the same cycle, the bit remains set.
- R8: A read at address 5 returns every active status bit, whatever the mask holds.
- R9: `irq_n` is low in the cycle after the bitwise AND of status and mask is non-zero, and high in the cycle after it is zero.
- R10: While `rst_n` is low, every written register reads 0, `tx_load` is 0, `irq_n` is 1, the latched status bits are 0 and the pointer is at the first mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data |
| stat_in | input | 8 | Channel status byte |
| brg_probe | input | 8 | Baud generator probe value |
| rx_hold | input | 8 | Received character |
| clk_probe | input | 8 | Clock-mode probe value |
| cnt_hi | input | 8 | Counter value, upper byte |
| cnt_lo | input | 8 | Counter value, lower byte |
| lvl_txrdy | input | 1 | Transmit holding ready level |
| lvl_txemt | input | 1 | Transmit shifter empty level |
| lvl_rxrdy | input | 1 | Receive ready or FIFO full level |
| lvl_pin | input | 1 | Input pin level |
| pls_brk | input | 1 | Break status changed, one-cycle pulse |
| pls_cnt | input | 1 | Counter terminal count, one-cycle pulse |
| pls_pin | input | 1 | Input pin changed, one-cycle pulse |
| mode1 | output | 8 | First mode register |
| mode2 | output | 8 | Second mode register |
| clk_sel | output | 8 | Clock select register |
| aux_ctl | output | 8 | Auxiliary control register |
| cnt_pre_hi | output | 8 | Counter preset, upper byte |
| cnt_pre_lo | output | 8 | Counter preset, lower byte |
| tx_hold | output | 8 | Transmit holding register |
| tx_load | output | 1 | One-clock pulse on a transmit holding write |
| irq_n | output | 1 | Registered active-low interrupt |

## Verification
A pointer in the wrong state sends the next address-0 access to the other mode register. This appears on `mode1`/`mode2` one clock later, and on `rd_data` as soon as address 0 is read. A latched status bit that is stuck or clears wrongly appears in the unmasked status byte on the next read of address 5, and on `irq_n` one clock after it is enabled in the mask. Because every output is compared against a behavioural model on every clock, a divergence is reported in the cycle in which it first reaches a port.

// File: rtl/uart_regbank.sv
module uart_regbank #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic [2:0]    addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rd_data,
  input  logic [DW-1:0] stat_in,
  input  logic [DW-1:0] brg_probe,
  input  logic [DW-1:0] rx_hold,
  input  logic [DW-1:0] clk_probe,
  input  logic [DW-1:0] cnt_hi,
  input  logic [DW-1:0] cnt_lo,
  input  logic          lvl_txrdy,
  input  logic          lvl_txemt,
  input  logic          lvl_rxrdy,
  input  logic          lvl_pin,
  input  logic          pls_brk,
  input  logic          pls_cnt,
  input  logic          pls_pin,
  output logic [DW-1:0] mode1,
  output logic [DW-1:0] mode2,
  output logic [DW-1:0] clk_sel,
  output logic [DW-1:0] aux_ctl,
  output logic [DW-1:0] cnt_pre_hi,
  output logic [DW-1:0] cnt_pre_lo,
  output logic [DW-1:0] tx_hold,
  output logic          tx_load,
  output logic          irq_n
);
  localparam logic [3:0] CMD_PTR = 4'b0001;
  localparam logic [3:0] CMD_BRK = 4'b0101;
  localparam logic [3:0] CMD_CTR = 4'b1001;

  logic       wr_d, rd_d, ptr;
  logic       brk_chg, ctr_rdy, pin_chg;
  logic [7:0] imr;
  logic [7:0] isr;

  wire wr_on = !cs_n && !wr_n;
  wire rd_on = !cs_n && !rd_n;
  wire wr_go = wr_on && !wr_d;
  wire rd_go = rd_on && !rd_d;

  wire       cmd_go  = wr_go && (addr == 3'd2);
  wire [3:0] cmd     = wdata[DW-1:DW-4];
  wire       ptr_rst = cmd_go && (cmd == CMD_PTR);
  wire       brk_clr = cmd_go && (cmd == CMD_BRK);
  wire       ctr_clr = cmd_go && (cmd == CMD_CTR);
  wire       pin_clr = rd_go && (addr == 3'd5);

  assign isr = {1'b0, lvl_pin, pin_chg, ctr_rdy, brk_chg, lvl_rxrdy, lvl_txemt, lvl_txrdy};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_d <= 1'b0;
      rd_d <= 1'b0;
    end else begin
      wr_d <= wr_on;
      rd_d <= rd_on;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= 1'b0;
    else if (ptr_rst)
      ptr <= 1'b0;
    else if ((wr_go || rd_go) && addr == 3'd0)
      ptr <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode1      <= '0;
      mode2      <= '0;
      clk_sel    <= '0;
      aux_ctl    <= '0;
      cnt_pre_hi <= '0;
      cnt_pre_lo <= '0;
      tx_hold    <= '0;
      imr        <= '0;
      tx_load    <= 1'b0;
    end else begin
      tx_load <= 1'b0;
      if (wr_go) begin
        case (addr)
          3'd0: if (ptr) mode2 <= wdata; else mode1 <= wdata;
          3'd1: clk_sel <= wdata;
          3'd3: begin tx_hold <= wdata; tx_load <= 1'b1; end
          3'd4: aux_ctl <= wdata;
          3'd5: imr <= wdata[7:0];
          3'd6: cnt_pre_hi <= wdata;
          3'd7: cnt_pre_lo <= wdata;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_chg <= 1'b0;
      ctr_rdy <= 1'b0;
      pin_chg <= 1'b0;
      irq_n   <= 1'b1;
    end else begin
      brk_chg <= pls_brk | (brk_chg & ~brk_clr);
      ctr_rdy <= pls_cnt | (ctr_rdy & ~ctr_clr);
      pin_chg <= pls_pin | (pin_chg & ~pin_clr);
      irq_n   <= ~|(isr & imr);
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_on) begin
      case (addr)
        3'd0: rd_data = ptr ? mode2 : mode1;
        3'd1: rd_data = stat_in;
        3'd2: rd_data = brg_probe;
        3'd3: rd_data = rx_hold;
        3'd4: rd_data = clk_probe;
        3'd5: rd_data = isr;
        3'd6: rd_data = cnt_hi;
        default: rd_data = cnt_lo;
      endcase
    end
  end
endmodule

// File: rtl/uart_regbank_chk.sv
module uart_regbank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rd_n,
  input logic [7:0] rd_data,
  input logic [7:0] isr,
  input logic [7:0] imr,
  input logic       irq_n,
  input logic       ptr,
  input logic       ptr_rst,
  input logic       brk_clr,
  input logic       pls_brk,
  input logic       tx_load
);
  a_r9_irq_low: assert property (@(posedge clk) disable iff (!rst_n)
    (|(isr & imr)) |=> !irq_n);
  a_r9_irq_high: assert property (@(posedge clk) disable iff (!rst_n)
    !(|(isr & imr)) |=> irq_n);
  a_r3_ptr_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (ptr && !ptr_rst) |=> ptr);
  a_r4_ptr_reset: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_rst |=> !ptr);
  a_r6_brk_set: assert property (@(posedge clk) disable iff (!rst_n)
    pls_brk |=> isr[3]);
  a_r7_brk_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_clr && !pls_brk) |=> !isr[3]);
  a_r1_load_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load |=> !tx_load);
  a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n || rd_n) |-> (rd_data == 8'h00));
endmodule

bind uart_regbank uart_regbank_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .rd_data(rd_data),
  .isr(isr), .imr(imr), .irq_n(irq_n), .ptr(ptr), .ptr_rst(ptr_rst),
  .brk_clr(brk_clr), .pls_brk(pls_brk), .tx_load(tx_load)
);

// File: tb/sim_uart_regbank.sv
module sim_uart_regbank;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0, stat_in = '0, brg_probe = '0, rx_hold = '0, clk_probe = '0;
  logic [7:0] cnt_hi = '0, cnt_lo = '0;
  logic lvl_txrdy = 0, lvl_txemt = 0, lvl_rxrdy = 0, lvl_pin = 0;
  logic pls_brk = 0, pls_cnt = 0, pls_pin = 0;
  logic [7:0] rd_data, mode1, mode2, clk_sel, aux_ctl, cnt_pre_hi, cnt_pre_lo, tx_hold;
  logic tx_load, irq_n;

  uart_regbank u0 (.*);

  int n_cmp = 0, n_bad = 0;

  logic [7:0] e_m1 = 0, e_m2 = 0, e_csr = 0, e_acr = 0, e_hi = 0, e_lo = 0, e_imr = 0, e_thr = 0;
  logic e_load = 0, e_ptr = 0, e_brk = 0, e_ctr = 0, e_pc = 0, e_irq_n = 1, e_wd = 0, e_rd = 0;

  function automatic logic [7:0] m_isr();
    return {1'b0, lvl_pin, e_pc, e_ctr, e_brk, lvl_rxrdy, lvl_txemt, lvl_txrdy};
  endfunction

  always @(posedge clk) begin
    logic [7:0] iold;
    logic wg, rg, cg;
    if (!rst_n) begin
      e_m1 = 0; e_m2 = 0; e_csr = 0; e_acr = 0; e_hi = 0; e_lo = 0; e_imr = 0; e_thr = 0;
      e_load = 0; e_ptr = 0; e_brk = 0; e_ctr = 0; e_pc = 0; e_irq_n = 1; e_wd = 0; e_rd = 0;
    end else begin
      iold = m_isr();
      wg = !cs_n && !wr_n && !e_wd;
      rg = !cs_n && !rd_n && !e_rd;
      cg = wg && addr == 3'd2;
      e_irq_n = ((iold & e_imr) == 8'h00);
      e_load = 0;
      if (wg) begin
        if (addr == 0) begin if (e_ptr) e_m2 = wdata; else e_m1 = wdata; end
        if (addr == 1) e_csr = wdata;
        if (addr == 3) begin e_thr = wdata; e_load = 1; end
        if (addr == 4) e_acr = wdata;
        if (addr == 5) e_imr = wdata;
        if (addr == 6) e_hi = wdata;
        if (addr == 7) e_lo = wdata;
      end
      e_brk = pls_brk || (e_brk && !(cg && wdata[7:4] == 4'd5));
      e_ctr = pls_cnt || (e_ctr && !(cg && wdata[7:4] == 4'd9));
      e_pc  = pls_pin || (e_pc && !(rg && addr == 3'd5));
      if (cg && wdata[7:4] == 4'd1) e_ptr = 0;
      else if ((wg || rg) && addr == 3'd0) e_ptr = 1;
      e_wd = !cs_n && !wr_n;
      e_rd = !cs_n && !rd_n;
    end
  end

  function automatic logic [7:0] exp_rd();
    if (cs_n || rd_n) return 8'h00;
    case (addr)
      3'd0: return e_ptr ? e_m2 : e_m1;
      3'd1: return stat_in;
      3'd2: return brg_probe;
      3'd3: return rx_hold;
      3'd4: return clk_probe;
      3'd5: return m_isr();
      3'd6: return cnt_hi;
      default: return cnt_lo;
    endcase
  endfunction

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(mode1, e_m1, "R3 R4 mode1");
      chk(mode2, e_m2, "R3 R4 mode2");
      chk(clk_sel, e_csr, "R1 clk_sel");
      chk(aux_ctl, e_acr, "R1 aux_ctl");
      chk(cnt_pre_hi, e_hi, "R1 cnt_pre_hi");
      chk(cnt_pre_lo, e_lo, "R1 cnt_pre_lo");
      chk(tx_hold, e_thr, "R1 tx_hold");
      chk({7'd0, tx_load}, {7'd0, e_load}, "R1 tx_load");
      chk({7'd0, irq_n}, {7'd0, e_irq_n}, "R9 irq_n");
      if (addr == 3'd0) chk(rd_data, exp_rd(), "R3 rd_data");
      else if (addr == 3'd5) chk(rd_data, exp_rd(), "R5 R6 R7 R8 rd_data");
      else chk(rd_data, exp_rd(), "R2 rd_data");
    end
  end

  task automatic bus(input logic wr, input logic [2:0] a, input logic [7:0] d, input int hold);
    @(negedge clk);
    addr = a; wdata = d; cs_n = 0;
    if (wr) wr_n = 0; else rd_n = 0;
    repeat (hold) @(negedge clk);
    cs_n = 1; wr_n = 1; rd_n = 1;
  endtask

  task automatic pulse(input logic b, input logic c, input logic p);
    @(negedge clk);
    pls_brk = b; pls_cnt = c; pls_pin = p;
    @(negedge clk);
    pls_brk = 0; pls_cnt = 0; pls_pin = 0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(mode1, 8'h00, "R10 mode1 reset");
    chk(tx_hold, 8'h00, "R10 tx_hold reset");
    chk({7'd0, irq_n}, 8'h01, "R10 irq_n reset");
    chk({7'd0, tx_load}, 8'h00, "R10 tx_load reset");
    @(negedge clk); rst_n = 1;

    // R3: pointer sequencing, held strobes count once
    bus(1, 0, 8'h11, 2);
    bus(1, 0, 8'h22, 3);
    bus(1, 0, 8'h33, 1);
    bus(0, 0, 8'h00, 2);
    // R4: pointer reset command
    bus(1, 2, 8'h10, 1);
    bus(0, 0, 8'h00, 2);
    bus(0, 0, 8'h00, 1);
    // R1: every write address
    bus(1, 1, 8'hA1, 1); bus(1, 3, 8'hB3, 3); bus(1, 4, 8'hC4, 1);
    bus(1, 6, 8'hD6, 1); bus(1, 7, 8'hE7, 2);
    // R2: every read address
    stat_in = 8'h5A; brg_probe = 8'h3C; rx_hold = 8'h96; clk_probe = 8'h69;
    cnt_hi = 8'hF0; cnt_lo = 8'h0F;
    for (int a = 1; a < 8; a++) bus(0, a[2:0], 8'h00, 1);
    // R5 R8 R9: levels, unmasked read, masked interrupt
    lvl_txrdy = 1; lvl_pin = 1;
    bus(0, 5, 8'h00, 1);
    bus(1, 5, 8'h02, 1);
    lvl_txemt = 1; repeat (2) @(negedge clk);
    bus(1, 5, 8'h40, 1);
    lvl_pin = 0; repeat (2) @(negedge clk);
    // R6 R7: sticky bits and clears
    bus(1, 5, 8'h38, 1);
    pulse(1, 1, 1);
    bus(0, 5, 8'h00, 1);
    bus(1, 2, 8'h50, 1);
    bus(1, 2, 8'h90, 1);
    bus(0, 5, 8'h00, 2);
    // R7: set and clear in the same cycle keep the bit
    @(negedge clk); addr = 2; wdata = 8'h50; cs_n = 0; wr_n = 0; pls_brk = 1;
    @(negedge clk); cs_n = 1; wr_n = 1; pls_brk = 0;
    @(negedge clk); addr = 5; cs_n = 0; rd_n = 0; pls_pin = 1;
    @(negedge clk); cs_n = 1; rd_n = 1; pls_pin = 0;
    bus(0, 5, 8'h00, 1);
    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] r;
      r = 8'($urandom);
      lvl_txrdy = r[0]; lvl_txemt = r[1]; lvl_rxrdy = r[2]; lvl_pin = r[3];
      stat_in = 8'($urandom); rx_hold = 8'($urandom); cnt_lo = 8'($urandom);
      if (r[7:6] == 2'd0) pulse(r[4], r[5], r[3]);
      else if (r[7:6] == 2'd1) bus(1, 3'd2, {4'($urandom), 4'd0}, 1);
      else bus(r[6], 3'($urandom), 8'($urandom), 1 + int'(r[5:4]));
    end
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule